// File: doc/BRIEF.md
# Gradual Dimming Step Sequencer

This block moves a 5-bit LED current level code, one code per step, from wherever it sits to a programmed end level. Two end-level registers are supplied, one for brightening and one for dimming. A one-bit tag says which of the two was written most recently, and that one becomes the end level when a run command arrives. The run command also carries a 5-bit step-time code. Each step lasts that code times a unit interval. The unit interval is a parameterised number of 1 MHz ticks, 8000 by default, which gives 8 ms.

No division is needed. The number of steps is the distance between the present level and the end level, and the whole ramp lasts that distance times the step time. A level at the ceiling code is held to the highest legal level, so the output never goes outside 0 to 30. A direct level load skips the ramp and sets the level at once. Shutdown forces the level to zero. A busy flag is high while a ramp is in progress.

Top module: `dim_ramp_seq`

## Requirements
- R1: Out of reset `level_o` is 0 and `busy_o` is 0.
- R2: One step takes `step_time_i` × `UNIT_TICKS` tick pulses, with `step_time_i` an unsigned count of unit intervals (bit weights 1, 2, 4, 8, 16). The time code is captured when the run command is accepted.
- R3: A ramp makes |end − start| steps. With a tick on every clock, `busy_o` is high for exactly steps × `step_time_i` × `UNIT_TICKS` clock cycles, starting the cycle after the run command.
- R4: `aim_up_i` = 1 selects `up_target_i` as the end level and 0 selects `down_target_i`. The level moves one code toward the end level per step, and `busy_o` drops in the same cycle that the level reaches it.
- R5: An end level or a loaded level of 31 is treated as 30, so `level_o` never exceeds 30.
- R6: `load_i` sets `level_o` to `load_code_i` (after R5) on the next cycle and ends any ramp in progress.
- R7: A run command with `step_time_i` = 0 is ignored: `level_o` and `busy_o` keep their values.
- R8: A run command whose end level equals the present level leaves `busy_o` low and the level unchanged.
- R9: A run command during a ramp restarts from the present level with the new end level and time code, and the step timing restarts from zero.
- R10: `shutdown_i` overrides load and run. On the next cycle `level_o` is 0 and `busy_o` is 0.
- R11: Outside load and shutdown, `level_o` changes by at most one code per cycle.
- R12: While `tick_i` is low a ramp makes no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 1 MHz time-base pulse, one clock wide |
| up_target_i | input | 5 | End level used for brightening |
| down_target_i | input | 5 | End level used for dimming |
| aim_up_i | input | 1 | 1 if the brightening end level was written last |
| step_time_i | input | 5 | Unit intervals per step |
| run_i | input | 1 | Start pulse of a ramp |
| load_i | input | 1 | Direct level load request |
| load_code_i | input | 5 | Level for a direct load |
| shutdown_i | input | 1 | Force level to zero |
| level_o | output | 5 | Present current level code |
| busy_o | output | 1 | Ramp in progress |

## Verification
The assertions assume that the command strobes (`run_i`, `load_i`, `shutdown_i`) and `tick_i` are single-clock pulses sampled on rising edges. They also assume that end levels and the time code are stable in the cycle a run is issued. The stimulus changes inputs only on falling edges and lowers every strobe one cycle after raising it. The bench runs the tick on every clock, except in the phase that holds it low on purpose. This makes the step length an exact number of cycles that the bench can predict. The bench builds the unit with `UNIT_TICKS` = 2 so that full 30-step ramps stay short.

// File: rtl/dim_ramp_pkg.sv
package dim_ramp_pkg;

   // Command seen by the level register, already resolved by priority.
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_RUN  = 2'd1,
      CMD_LOAD = 2'd2,
      CMD_OFF  = 2'd3
   } ramp_cmd_e;

endpackage

// File: rtl/dim_cmd_decode.sv
module dim_cmd_decode
   import dim_ramp_pkg::*;
#(
   parameter int CODE_W = 5,
   parameter int TIME_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shutdown_i,
   input  logic              load_i,
   input  logic [CODE_W-1:0] load_code_i,
   input  logic              run_i,
   input  logic              aim_up_i,
   input  logic [CODE_W-1:0] up_target_i,
   input  logic [CODE_W-1:0] down_target_i,
   input  logic [TIME_W-1:0] step_time_i,
   output ramp_cmd_e         cmd_o,
   output logic [CODE_W-1:0] value_o
);

   // The all-ones code is folded onto the one below it.
   localparam logic [CODE_W-1:0] CEIL = CODE_W'((1 << CODE_W) - 2);

   function automatic logic [CODE_W-1:0] fold(input logic [CODE_W-1:0] v);
      return (v > CEIL) ? CEIL : v;
   endfunction

   logic [CODE_W-1:0] aim_raw;
   logic              run_ok;

   assign aim_raw = aim_up_i ? up_target_i : down_target_i;
   assign run_ok  = run_i && (step_time_i != '0);

   always_comb begin
      cmd_o   = CMD_NONE;
      value_o = fold(aim_raw);
      if (shutdown_i) begin
         cmd_o   = CMD_OFF;
         value_o = '0;
      end else if (load_i) begin
         cmd_o   = CMD_LOAD;
         value_o = fold(load_code_i);
      end else if (run_ok) begin
         cmd_o   = CMD_RUN;
      end
   end

   // R7: a zero time code never turns into a run command
   assert_zero_time_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && step_time_i == '0 && !load_i && !shutdown_i) |-> cmd_o == CMD_NONE);

   // R10: shutdown wins over every other request
   assert_off_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shutdown_i |-> (cmd_o == CMD_OFF));

endmodule

// File: rtl/dim_interval_timer.sv
module dim_interval_timer #(
   parameter int TIME_W     = 5,
   parameter int UNIT_TICKS = 8000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              clr_i,
   input  logic              tick_i,
   input  logic [TIME_W-1:0] step_time_i,
   output logic              step_o
);

   localparam logic [TIME_W-1:0] ONE_T = TIME_W'(1);

   initial begin
      assert (UNIT_TICKS >= 1) else $error("UNIT_TICKS must be at least 1");
      assert (TIME_W >= 1) else $error("TIME_W must be at least 1");
   end

   logic              unit_tick;
   logic [TIME_W-1:0] unit_q;

   generate
      if (UNIT_TICKS == 1) begin : g_direct
         assign unit_tick = en_i & ~clr_i & tick_i;
      end else begin : g_prescale
         localparam int PRE_W = $clog2(UNIT_TICKS);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni || !en_i || clr_i) begin
               pre_q <= '0;
            end else if (tick_i) begin
               pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            end
         end

         assign unit_tick = en_i & ~clr_i & tick_i & (pre_q == PRE_LAST);
      end
   endgenerate

   assign step_o = unit_tick && (unit_q == step_time_i - ONE_T);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !en_i || clr_i) begin
         unit_q <= '0;
      end else if (unit_tick) begin
         unit_q <= step_o ? '0 : unit_q + 1'b1;
      end
   end

   // R2: the interval count never passes the captured time code
   assert_unit_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && step_time_i != '0) |-> (unit_q < step_time_i));

   // R12: without a tick there is no step
   assert_no_tick_no_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |-> !step_o);

endmodule

// File: rtl/dim_step_core.sv
module dim_step_core
   import dim_ramp_pkg::*;
#(
   parameter int CODE_W = 5,
   parameter int TIME_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  ramp_cmd_e         cmd_i,
   input  logic [CODE_W-1:0] value_i,
   input  logic [TIME_W-1:0] step_time_i,
   input  logic              step_i,
   output logic [CODE_W-1:0] level_o,
   output logic              busy_o,
   output logic [TIME_W-1:0] held_time_o
);

   localparam logic [CODE_W-1:0] CEIL = CODE_W'((1 << CODE_W) - 2);

   logic [CODE_W-1:0] level_q, aim_q, next_level;
   logic              busy_q;
   logic [TIME_W-1:0] time_q;

   assign next_level = (aim_q > level_q) ? level_q + 1'b1 : level_q - 1'b1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         level_q <= '0;
         aim_q   <= '0;
         busy_q  <= 1'b0;
         time_q  <= '0;
      end else begin
         unique case (cmd_i)
            CMD_OFF: begin
               level_q <= '0;
               busy_q  <= 1'b0;
            end
            CMD_LOAD: begin
               level_q <= value_i;
               busy_q  <= 1'b0;
            end
            CMD_RUN: begin
               aim_q  <= value_i;
               time_q <= step_time_i;
               busy_q <= (value_i != level_q);
            end
            default: begin
               if (busy_q && step_i) begin
                  level_q <= next_level;
                  if (next_level == aim_q) busy_q <= 1'b0;
               end
            end
         endcase
      end
   end

   assign level_o     = level_q;
   assign busy_o      = busy_q;
   assign held_time_o = time_q;

   // R5: level stays at or below the ceiling code
   assert_level_ceiling_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_q <= CEIL);

   // R11: one code per cycle at most unless loaded or shut down
   assert_single_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i != CMD_LOAD && cmd_i != CMD_OFF) |=>
         (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1) ||
         ($past(level_q) == level_q + 1'b1));

   // R10: shutdown leaves a dark, idle sequencer
   assert_shutdown_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_OFF) |=> (level_q == '0 && !busy_q));

   // R4: a ramp only finishes on its end level
   assert_done_at_aim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(busy_q) && $past(cmd_i) == CMD_NONE) |-> (level_q == aim_q));

   // R8: run toward the present level never raises busy
   assert_trivial_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_RUN && value_i == level_q) |=> !busy_q);

   // R6: a load always ends the ramp
   assert_load_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_LOAD) |=> (!busy_q && level_q == $past(value_i)));

endmodule

// File: rtl/dim_ramp_seq.sv
module dim_ramp_seq
   import dim_ramp_pkg::*;
#(
   parameter int CODE_W     = 5,
   parameter int TIME_W     = 5,
   parameter int UNIT_TICKS = 8000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] up_target_i,
   input  logic [CODE_W-1:0] down_target_i,
   input  logic              aim_up_i,
   input  logic [TIME_W-1:0] step_time_i,
   input  logic              run_i,
   input  logic              load_i,
   input  logic [CODE_W-1:0] load_code_i,
   input  logic              shutdown_i,
   output logic [CODE_W-1:0] level_o,
   output logic              busy_o
);

   initial begin
      assert (CODE_W >= 2) else $error("CODE_W must be at least 2");
   end

   ramp_cmd_e         cmd;
   logic [CODE_W-1:0] cmd_value;
   logic [TIME_W-1:0] held_time;
   logic              step;
   logic              busy;

   dim_cmd_decode #(.CODE_W(CODE_W), .TIME_W(TIME_W)) u_decode (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .shutdown_i    (shutdown_i),
      .load_i        (load_i),
      .load_code_i   (load_code_i),
      .run_i         (run_i),
      .aim_up_i      (aim_up_i),
      .up_target_i   (up_target_i),
      .down_target_i (down_target_i),
      .step_time_i   (step_time_i),
      .cmd_o         (cmd),
      .value_o       (cmd_value)
   );

   dim_interval_timer #(.TIME_W(TIME_W), .UNIT_TICKS(UNIT_TICKS)) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (busy),
      .clr_i       (cmd == CMD_RUN),
      .tick_i      (tick_i),
      .step_time_i (held_time),
      .step_o      (step)
   );

   dim_step_core #(.CODE_W(CODE_W), .TIME_W(TIME_W)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (cmd),
      .value_i     (cmd_value),
      .step_time_i (step_time_i),
      .step_i      (step),
      .level_o     (level_o),
      .busy_o      (busy),
      .held_time_o (held_time)
   );

   assign busy_o = busy;

   // R12: a stalled time base freezes the level
   assert_tick_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && cmd == CMD_NONE) |=> $stable(level_o));

endmodule

// File: tb/dim_ramp_seq_test.sv
module dim_ramp_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic [4:0] up_t = '0, dn_t = '0, st = '0, ld_code = '0;
   logic       aim_up = 1'b0, run = 1'b0, load = 1'b0, off = 1'b0;
   logic [4:0] level;
   logic       busy;

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   dim_ramp_seq #(.UNIT_TICKS(2)) uut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .up_target_i(up_t), .down_target_i(dn_t), .aim_up_i(aim_up),
      .step_time_i(st), .run_i(run), .load_i(load), .load_code_i(ld_code),
      .shutdown_i(off), .level_o(level), .busy_o(busy)
   );

   // start, aim_up, up end, down end, time code, final level, busy cycles (unit = 2 clocks)
   localparam int VEC [0:6][0:6] = '{
      '{ 5, 1, 15,  0,  2, 15,  40},
      '{20, 0,  0,  1,  4,  1, 152},
      '{ 0, 1, 31,  0,  1, 30,  60},
      '{31, 0,  0,  0,  1,  0,  60},
      '{12, 1, 12,  3,  3, 12,   0},
      '{10, 1,  3, 25,  1,  3,  14},
      '{30, 0,  0, 29, 31, 29,  62}
   };

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_load(input int c);
      @(negedge clk); load = 1'b1; ld_code = 5'(c);
      @(negedge clk); load = 1'b0;
   endtask

   task automatic launch(input bit a, input int u, input int d, input int t);
      @(negedge clk);
      aim_up = a; up_t = 5'(u); dn_t = 5'(d); st = 5'(t); run = 1'b1;
      @(negedge clk); run = 1'b0;
   endtask

   // counts busy cycles from the negedge after the run edge; flags jumps (R11)
   task automatic measure(output int cycles);
      int prev;
      cycles = 0;
      prev = int'(level);
      while (busy && cycles < 5000) begin
         cycles++;
         @(negedge clk);
         if (int'(level) - prev > 1 || prev - int'(level) > 1)
            check("R11 jump", int'(level), prev);
         prev = int'(level);
      end
   endtask

   initial begin
      #1_200_000;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      check("R1 level", int'(level), 0);
      check("R1 busy", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 7; i++) begin
         do_load(VEC[i][0]);
         launch(VEC[i][1] != 0, VEC[i][2], VEC[i][3], VEC[i][4]);
         measure(cyc);
         check($sformatf("R2 R3 vec%0d busy cycles", i), cyc, VEC[i][6]);
         check($sformatf("R4 R5 R8 vec%0d final level", i), int'(level), VEC[i][5]);
      end

      // R6 direct load, R5 folding of 31
      do_load(17);
      check("R6 load", int'(level), 17);
      do_load(31);
      check("R5 load 31", int'(level), 30);

      // R6 load during a ramp ends it
      do_load(0);
      launch(1'b1, 20, 0, 1);
      repeat (4) @(negedge clk);
      do_load(8);
      check("R6 load mid-ramp level", int'(level), 8);
      check("R6 load mid-ramp busy", int'(busy), 0);

      // R7 zero time code ignored
      do_load(9);
      launch(1'b1, 20, 0, 0);
      check("R7 level", int'(level), 9);
      check("R7 busy", int'(busy), 0);
      repeat (10) @(negedge clk);
      check("R7 level later", int'(level), 9);

      // R12 tick held low
      do_load(0);
      tick = 1'b0;
      launch(1'b1, 10, 0, 1);
      repeat (20) @(negedge clk);
      check("R12 level frozen", int'(level), 0);
      check("R12 busy held", int'(busy), 1);
      tick = 1'b1;
      measure(cyc);
      check("R12 cycles after release", cyc, 20);
      check("R12 final", int'(level), 10);

      // R9 restart mid-ramp
      do_load(0);
      launch(1'b1, 20, 0, 1);
      repeat (6) @(negedge clk);
      check("R9 level before restart", int'(level), 3);
      run = 1'b1; aim_up = 1'b0; dn_t = 5'd0; st = 5'd2;
      @(negedge clk); run = 1'b0;
      check("R9 level at restart", int'(level), 3);
      measure(cyc);
      check("R9 cycles", cyc, 12);
      check("R9 final", int'(level), 0);

      // R10 shutdown mid-ramp, and over a simultaneous load
      launch(1'b1, 30, 0, 1);
      repeat (10) @(negedge clk);
      off = 1'b1; load = 1'b1; ld_code = 5'd20;
      @(negedge clk); off = 1'b0; load = 1'b0;
      check("R10 level", int'(level), 0);
      check("R10 busy", int'(busy), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule